// File: doc/BRIEF.md
# Optical Disc Sector Sync Framer

This block sits on the byte stream of an optical disc data channel. It accepts one byte each time its strobe is high. It looks for the 12-byte sector sync mark: a zero byte, ten 0xFF bytes, then a closing zero byte. It counts the bytes of each 2352-byte sector, and it can supply a sync boundary by itself when the mark fails to arrive on time. At every sector boundary it updates four sync-quality status flags and pulses a decode interrupt. In write mode it loads a block pointer with the buffer address where the finished sector began. In monitor mode it captures the four header bytes that follow the boundary.

Four control inputs configure the block: detection enable, insertion enable, decode enable and write request. It also takes the current buffer write address. A decode-busy output stays high for a fixed window after each boundary that occurs while decoding is enabled. Every flag, pointer and header output is a register, and each one changes on the clock edge that accepts the byte responsible.

Top module: `sector_sync_framer`

## Requirements
- R1: A sync candidate is a zero byte that arrives after an opening zero byte and exactly ten 0xFF bytes. It counts as a sync only if its index in the accepted byte stream, counted from 0 at reset, is 3 modulo 4. A candidate at any other lane restarts the run as a new opening zero, and no boundary occurs.
- R2: When detection is disabled, a valid sync is ignored and causes no boundary. If no boundary occurs on that byte, the short-block flag (flag_short) is set.
- R3: The sector counter advances by one on every accepted byte. When insertion is enabled and the advanced count equals 2352, a boundary is inserted on that byte.
- R4: On a boundary byte, all four status flags are recomputed from that byte alone, so long and short flags read 0 afterwards. The sector counter restarts at 0.
- R5: flag_nosync is set on a boundary that was inserted on a byte that carried no detected or ignored sync. If an ignored sync falls on the inserted boundary, flag_nosync stays 0.
- R6: flag_illegal is set on a boundary produced by a detected sync whose advanced count is not 2352.
- R7: On a byte that is not a boundary, flag_long is set when the advanced count equals 2352. The flag stays set until the next boundary.
- R8: Each boundary sets hdr_stale and gives a single-cycle dec_irq pulse in the following cycle. hdr_stale clears on the fourth byte after the boundary.
- R9: On a boundary with decode enable and write request both set, blk_ptr loads wr_addr + 1 - 2352 modulo 2^16. Otherwise blk_ptr holds its value.
- R10: With decode enable set and write request clear, the k-th byte after a boundary (k = 1..4) is stored in hdr_data bits [8k-1:8k-8]. In every other mode hdr_data is unchanged.
- R11: A boundary taken while decode enable is set raises dec_busy for exactly 9408 (2352 x 4) clock cycles. A boundary taken with decode disabled does not raise dec_busy.
- R12: Reset clears every flag, counter, pointer and header register. Cycles with byte_vld low change no output except to end dec_irq and run down dec_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Byte strobe |
| byte_in | input | 8 | Channel byte |
| det_en | input | 1 | Sync detection enable |
| ins_en | input | 1 | Sync insertion enable |
| dec_en | input | 1 | Decode enable |
| wr_req | input | 1 | Write request (buffer write mode) |
| wr_addr | input | 16 | Current buffer write address |
| flag_illegal | output | 1 | Sync detected at wrong sector length |
| flag_nosync | output | 1 | Boundary was inserted, no sync seen |
| flag_long | output | 1 | Sector reached full length without boundary |
| flag_short | output | 1 | Sync ignored without boundary |
| hdr_stale | output | 1 | Header bytes of current sector not yet complete |
| dec_irq | output | 1 | One-cycle decode interrupt pulse |
| dec_busy | output | 1 | Decode window active |
| blk_ptr | output | 16 | Start address of the last finished block |
| hdr_data | output | 32 | Captured header bytes, first byte lowest |

## Verification
Two cases are hard to reach from the ports. The first is an ignored sync that lands on the same byte as an inserted boundary. It must suppress flag_nosync even though no sync was accepted. The bench reaches it by streaming a complete 2352-byte sector with a lane-aligned closing mark, with detection off and insertion on, so the two events coincide. The second is a sector that overruns 2352 bytes after an ignored mid-sector sync. The bench places the mark at a lane-aligned point, turns detection and insertion off, and pads until the bench's own count reaches 2352. This sets both flag_short and flag_long before a later illegal sync clears them.

// File: rtl/framer_pkg.sv
package framer_pkg;

    // opening zero plus ten 0xFF bytes
    localparam int RUN_FULL = 11;
    localparam int RUN_W    = 4;
    localparam int HDR_N    = 4;
    localparam logic [1:0] SYNC_LANE = 2'd3;

    typedef struct packed {
        logic illegal;
        logic nosync;
        logic lng;
        logic shrt;
    } sync_flags_t;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_DETECT = 2'd1,
        EV_IGNORE = 2'd2
    } sync_ev_e;

    function automatic logic [RUN_W-1:0] run_after(input logic [RUN_W-1:0] run,
                                                   input logic [7:0] b);
        logic [RUN_W-1:0] r;
        if (b == 8'h00)
            r = RUN_W'(1);
        else if (b == 8'hFF && run != '0)
            r = (run == '1) ? run : run + RUN_W'(1);
        else
            r = '0;
        return r;
    endfunction

endpackage

// File: rtl/sync_detect.sv
module sync_detect
    import framer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vld,
    input  logic [7:0] data,
    input  logic       det_en,
    output sync_ev_e   ev
);
    logic [RUN_W-1:0] run_q;
    logic [1:0]       lane_q;
    logic             hit;

    assign hit = vld && data == 8'h00 && run_q == RUN_W'(RUN_FULL) && lane_q == SYNC_LANE;

    always_comb begin
        ev = EV_NONE;
        if (hit)
            ev = det_en ? EV_DETECT : EV_IGNORE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            lane_q <= '0;
        end else if (vld) begin
            lane_q <= lane_q + 2'd1;
            run_q  <= hit ? '0 : run_after(run_q, data);
        end
    end

    // R1: a lane-3 hit leaves the run counter empty for the next byte
    p_hit_clears_run_r1: assert property (@(posedge clk) disable iff (rst)
        (ev != EV_NONE) |=> (run_q == '0));
endmodule

// File: rtl/sector_track.sv
module sector_track
    import framer_pkg::*;
#(
    parameter int SECT_LEN = 2352,
    parameter int CNT_W    = $clog2(SECT_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  sync_ev_e         ev,
    input  logic             ins_en,
    output logic             boundary,
    output logic [CNT_W-1:0] pos,
    output sync_flags_t      flags_q
);
    localparam logic [CNT_W-1:0] SECT_END = CNT_W'(SECT_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             det, ign, ins;

    assign cnt_inc  = cnt_q + CNT_W'(1);
    assign det      = (ev == EV_DETECT);
    assign ign      = (ev == EV_IGNORE);
    assign ins      = vld && ins_en && cnt_inc == SECT_END;
    assign boundary = det || ins;
    assign pos      = boundary ? '0 : cnt_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            flags_q <= '0;
        end else if (vld) begin
            if (boundary) begin
                flags_q.illegal <= det && cnt_inc != SECT_END;
                flags_q.nosync  <= ins && !det && !ign;
                flags_q.lng     <= 1'b0;
                flags_q.shrt    <= 1'b0;
                cnt_q           <= '0;
            end else begin
                cnt_q <= cnt_inc;
                if (ign)
                    flags_q.shrt <= 1'b1;
                if (cnt_inc == SECT_END)
                    flags_q.lng <= 1'b1;
            end
        end
    end

    // R4: a boundary leaves the length flags clear
    p_bnd_clears_len_r4: assert property (@(posedge clk) disable iff (rst)
        (vld && boundary) |=> (!flags_q.lng && !flags_q.shrt));
endmodule

// File: rtl/header_grab.sv
module header_grab
    import framer_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  vld,
    input  logic [7:0]            data,
    input  logic                  boundary,
    input  logic [CNT_W-1:0]      pos,
    input  logic                  dec_en,
    input  logic                  wr_req,
    output logic [HDR_N-1:0][7:0] hdr_q,
    output logic                  stale_q
);
    logic monitor;
    assign monitor = vld && !boundary && dec_en && !wr_req;

    for (genvar k = 0; k < HDR_N; k++) begin : g_hdr
        always_ff @(posedge clk) begin
            if (rst)
                hdr_q[k] <= '0;
            else if (monitor && pos == CNT_W'(k + 1))
                hdr_q[k] <= data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            stale_q <= 1'b0;
        else if (vld) begin
            if (boundary)
                stale_q <= 1'b1;
            else if (pos == CNT_W'(HDR_N))
                stale_q <= 1'b0;
        end
    end

    // R10: outside monitor mode the header bytes hold
    p_hdr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(vld && dec_en && !wr_req) |=> $stable(hdr_q));
endmodule

// File: rtl/sector_sync_framer.sv
module sector_sync_framer
    import framer_pkg::*;
#(
    parameter int SECT_LEN  = 2352,
    parameter int BUSY_MULT = 4,
    parameter int ADDR_W    = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  byte_vld,
    input  logic [7:0]            byte_in,
    input  logic                  det_en,
    input  logic                  ins_en,
    input  logic                  dec_en,
    input  logic                  wr_req,
    input  logic [ADDR_W-1:0]     wr_addr,
    output logic                  flag_illegal,
    output logic                  flag_nosync,
    output logic                  flag_long,
    output logic                  flag_short,
    output logic                  hdr_stale,
    output logic                  dec_irq,
    output logic                  dec_busy,
    output logic [ADDR_W-1:0]     blk_ptr,
    output logic [8*HDR_N-1:0]    hdr_data
);
    localparam int CNT_W    = $clog2(SECT_LEN + 1);
    localparam int BUSY_CYC = SECT_LEN * BUSY_MULT;
    localparam int BUSY_W   = $clog2(BUSY_CYC + 1);

    sync_ev_e              ev;
    logic                  bnd;
    logic [CNT_W-1:0]      pos;
    sync_flags_t           flags;
    logic [HDR_N-1:0][7:0] hdr;
    logic [BUSY_W-1:0]     busy_q;

    sync_detect u_det (
        .clk(clk), .rst(rst), .vld(byte_vld), .data(byte_in),
        .det_en(det_en), .ev(ev)
    );

    sector_track #(.SECT_LEN(SECT_LEN), .CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst(rst), .vld(byte_vld), .ev(ev), .ins_en(ins_en),
        .boundary(bnd), .pos(pos), .flags_q(flags)
    );

    header_grab #(.CNT_W(CNT_W)) u_hdr (
        .clk(clk), .rst(rst), .vld(byte_vld), .data(byte_in),
        .boundary(bnd), .pos(pos), .dec_en(dec_en), .wr_req(wr_req),
        .hdr_q(hdr), .stale_q(hdr_stale)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_irq <= 1'b0;
            blk_ptr <= '0;
            busy_q  <= '0;
        end else begin
            dec_irq <= bnd;
            if (bnd && dec_en && wr_req)
                blk_ptr <= wr_addr + ADDR_W'(1) - ADDR_W'(SECT_LEN);
            if (bnd && dec_en)
                busy_q <= BUSY_W'(BUSY_CYC);
            else if (busy_q != '0)
                busy_q <= busy_q - BUSY_W'(1);
        end
    end

    assign dec_busy     = (busy_q != '0);
    assign flag_illegal = flags.illegal;
    assign flag_nosync  = flags.nosync;
    assign flag_long    = flags.lng;
    assign flag_short   = flags.shrt;
    assign hdr_data     = hdr;

    // R8: interrupt is a single-cycle pulse
    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        dec_irq |=> !dec_irq);
    // R5: an inserted-only boundary and a detected sync never flag together
    p_flag_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(flag_illegal && flag_nosync));
    // R9: pointer only moves on a write-mode boundary
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(bnd && dec_en && wr_req) |=> $stable(blk_ptr));
    // R11: decode window opens on a decoding boundary
    p_busy_load_r11: assert property (@(posedge clk) disable iff (rst)
        (bnd && dec_en) |=> dec_busy);
endmodule

// File: tb/sector_sync_framer_tb_top.sv
module sector_sync_framer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SL = 2352;

    logic        clk = 0, rst = 1;
    logic        byte_vld = 0;
    logic [7:0]  byte_in = 0;
    logic        det_en = 0, ins_en = 0, dec_en = 0, wr_req = 0;
    logic [15:0] wr_addr = 0;
    logic        flag_illegal, flag_nosync, flag_long, flag_short;
    logic        hdr_stale, dec_irq, dec_busy;
    logic [15:0] blk_ptr;
    logic [31:0] hdr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_sync_framer dut_i (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .det_en(det_en), .ins_en(ins_en), .dec_en(dec_en), .wr_req(wr_req),
        .wr_addr(wr_addr), .flag_illegal(flag_illegal), .flag_nosync(flag_nosync),
        .flag_long(flag_long), .flag_short(flag_short), .hdr_stale(hdr_stale),
        .dec_irq(dec_irq), .dec_busy(dec_busy), .blk_ptr(blk_ptr), .hdr_data(hdr_data)
    );

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;
    bit busy_seen;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model state, from the requirements
    int m_run = 0, m_lane = 0, m_sc = 0;
    bit m_ill, m_nos, m_lng, m_sht, m_stale, m_irq;
    logic [15:0] m_ptr = 0;
    logic [31:0] m_hdr = 0;

    typedef struct {
        int          due;
        logic [3:0]  fl;
        bit          st;
        bit          irq;
        logic [15:0] ptr;
        logic [31:0] hdr;
    } exp_t;
    exp_t q[$];

    task automatic model_step(input logic [7:0] b, input bit v);
        int inc;
        bit det, ign, ins, bnd;
        m_irq = 0;
        if (!v) return;
        inc = (m_sc + 1) % 4096;
        det = 0; ign = 0;
        if (b == 8'h00) begin
            if (m_run == 11 && m_lane == 3) begin
                det = det_en; ign = !det_en; m_run = 0;
            end else m_run = 1;
        end else if (b == 8'hFF && m_run != 0) begin
            if (m_run < 15) m_run++;
        end else m_run = 0;
        m_lane = (m_lane + 1) % 4;
        ins = ins_en && inc == SL;
        bnd = det || ins;
        m_irq = bnd;
        if (bnd) begin
            m_ill = det && inc != SL;
            m_nos = ins && !det && !ign;
            m_lng = 0; m_sht = 0; m_sc = 0; m_stale = 1;
            if (dec_en && wr_req) m_ptr = wr_addr + 16'd1 - 16'(SL);
        end else begin
            m_sc = inc;
            if (ign) m_sht = 1;
            if (inc == SL) m_lng = 1;
            if (inc >= 1 && inc <= 4) begin
                if (dec_en && !wr_req) m_hdr[8*(inc-1) +: 8] = b;
                if (inc == 4) m_stale = 0;
            end
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input bit v);
        exp_t e;
        @(negedge clk);
        busy_seen = dec_busy;
        byte_in = b; byte_vld = v;
        model_step(b, v);
        e.due = cyc + 1;
        e.fl = {m_ill, m_nos, m_lng, m_sht};
        e.st = m_stale; e.irq = m_irq; e.ptr = m_ptr; e.hdr = m_hdr;
        q.push_back(e);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(flag_illegal == e.fl[3], "R6", "flag_illegal", flag_illegal, e.fl[3]);
            chk(flag_nosync  == e.fl[2], "R5", "flag_nosync", flag_nosync, e.fl[2]);
            chk(flag_long    == e.fl[1], "R7", "flag_long", flag_long, e.fl[1]);
            chk(flag_short   == e.fl[0], "R2", "flag_short", flag_short, e.fl[0]);
            chk(hdr_stale == e.st, "R8", "hdr_stale", hdr_stale, e.st);
            chk(dec_irq == e.irq, "R8", "dec_irq", dec_irq, e.irq);
            chk(blk_ptr == e.ptr, "R9", "blk_ptr", blk_ptr, e.ptr);
            chk(hdr_data == e.hdr, "R10", "hdr_data", hdr_data, e.hdr);
        end
    end

    function automatic logic [7:0] fill(input int i);
        return 8'((i * 13) % 200 + 20);
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) push_byte(8'h00, 0);
    endtask

    task automatic ctl(input bit d, input bit i, input bit de, input bit w,
                       input logic [15:0] a);
        push_byte(8'h00, 0);
        det_en = d; ins_en = i; dec_en = de; wr_req = w; wr_addr = a;
    endtask

    task automatic pattern();
        push_byte(8'h00, 1);
        for (int i = 0; i < 10; i++) push_byte(8'hFF, 1);
        push_byte(8'h00, 1);
    endtask

    task automatic send_sync();
        int i = 0;
        while ((m_lane + 11) % 4 != 3) begin push_byte(fill(i), 1); i++; end
        pattern();
    endtask

    task automatic send_sector(input logic [31:0] h, input bit with_sync);
        for (int k = 0; k < 4; k++) push_byte(h[8*k +: 8], 1);
        for (int i = 0; i < SL - 16; i++) push_byte(fill(i), 1);
        if (with_sync) pattern();
        else for (int i = 0; i < 12; i++) push_byte(fill(i + 7), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R12 reset state
        chk({flag_illegal, flag_nosync, flag_long, flag_short, hdr_stale, dec_irq, dec_busy} == 7'b0,
            "R12", "reset flags", {flag_illegal, flag_nosync, flag_long, flag_short, hdr_stale, dec_irq, dec_busy}, 0);
        chk(blk_ptr == 0 && hdr_data == 0, "R12", "reset ptr/hdr", blk_ptr, 0);

        // Phase A: misaligned mark, then aligned mark, write mode
        ctl(1, 0, 1, 1, 16'h0100);
        while ((m_lane + 11) % 4 != 0) push_byte(fill(m_lane), 1);
        pattern();
        idle(1);
        chk(hdr_stale == 0 && flag_illegal == 0, "R1", "misaligned sync ignored", hdr_stale, 0);
        send_sync();
        idle(1);
        chk(blk_ptr == 16'hF7D1, "R9", "block pointer", blk_ptr, 16'hF7D1);
        chk(flag_illegal == 1, "R6", "early sync illegal", flag_illegal, 1);

        // Phase B: monitor mode, header captured
        ctl(1, 0, 1, 0, 16'h0200);
        send_sector(32'h44332211, 1);
        idle(1);
        chk(hdr_data == 32'h44332211, "R10", "monitor header", hdr_data, 32'h44332211);
        chk(flag_illegal == 0, "R6", "full-length sync legal", flag_illegal, 0);

        // Phase C: write mode, header not captured
        ctl(1, 0, 1, 1, 16'h0000);
        send_sector(32'h88776655, 1);
        idle(1);
        chk(hdr_data == 32'h44332211, "R10", "header held in write mode", hdr_data, 32'h44332211);
        chk(blk_ptr == 16'hF6D1, "R9", "pointer wrap", blk_ptr, 16'hF6D1);

        // Phase D: ignored sync coincides with insertion
        ctl(0, 1, 1, 1, 16'h0000);
        send_sector(32'h0C0B0A09, 1);
        idle(1);
        chk(flag_nosync == 0 && hdr_stale == 1, "R5", "ignored+inserted nosync", flag_nosync, 0);

        // Phase E: insertion with no mark
        ctl(1, 1, 1, 1, 16'h1234);
        send_sector(32'h10203040, 0);
        idle(1);
        chk(flag_nosync == 1 && hdr_stale == 1, "R3", "inserted boundary", flag_nosync, 1);

        // Phase F: ignored mid-sector, then overrun
        ctl(0, 0, 1, 0, 16'h0000);
        for (int i = 0; i < 100; i++) push_byte(fill(i), 1);
        send_sync();
        idle(1);
        chk(flag_short == 1 && hdr_stale == 0, "R2", "short flag no boundary", flag_short, 1);
        while (m_sc != SL) push_byte(fill(m_sc), 1);
        idle(1);
        chk(flag_long == 1, "R7", "long flag", flag_long, 1);
        ctl(1, 0, 1, 0, 16'h0000);
        for (int i = 0; i < 20; i++) push_byte(fill(i), 1);
        send_sync();
        n = 0;
        do begin
            push_byte(8'h00, 0);
            if (busy_seen) n++;
        end while (busy_seen && n < 20000);
        chk(flag_long == 0 && flag_short == 0, "R4", "boundary clears length flags",
            {flag_long, flag_short}, 0);
        chk(n == SL * 4, "R11", "busy length", n, SL * 4);

        // decode disabled: no busy window
        ctl(1, 0, 0, 0, 16'h0000);
        for (int i = 0; i < 20; i++) push_byte(fill(i), 1);
        send_sync();
        idle(2);
        chk(dec_busy == 0 && hdr_stale == 1, "R11", "no busy without decode", dec_busy, 0);

        idle(4);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule